// File: doc/BRIEF.md
# Timer Shadow Register Update Control

This block is the control core of a general-purpose timer. It holds a small control word with four fields: the run enable, a reload buffer switch, a channel-control preload switch and a selector for the second update source. Software writes that word, the counter reload value and the output-control bits of each channel through a simple register port. The block decides when those writes become visible on the active outputs that the counter and the output stage use.

Two update events govern the transfers. The first is a software strobe or the counter wrapping. When buffering is on, it moves the buffered reload value into the active reload. The second is a software strobe or, if selected, a rising edge on the trigger input. When preload is on, it moves the buffered channel controls into the active set. The block contains its own up-counter, so the reload behaviour can be seen on a port. In single-pulse and slave-trigger modes, a trigger rising edge turns the timer on without software.

Top module: `tmr_shadow_ctl`

## Requirements
- R1: The control word at address 0 holds run enable at bit 0, reload buffer switch at bit 1, channel preload switch at bit 8 and second-update source select at bit 9. Every other bit reads as 0.
- R2: After reset the control word, the buffered and active reload, the buffered and active channel controls and the counter are all zero.
- R3: With the reload buffer switch at 0, a write to the reload register (address 1) appears on the active reload (read at address 2 and on `reload_o`) on the next cycle.
- R4: With the reload buffer switch at 1, a reload write changes only the buffered copy. The active reload changes only on an update event, which is `sw_upd` or a counter wrap.
- R5: With preload at 0, a write to channel register n (address 4+n; bit 0 enable, bit 1 complementary enable, bits 4:2 output mode) appears in the active channel set (address 8+n and the channel outputs) on the next cycle.
- R6: With preload at 1, channel writes change only the buffered copies. The active set takes all buffered values on the second update event and is unchanged by `sw_upd`.
- R7: With preload at 1 and the source select at 1, a rising edge of `trig_in` is also a second update event. A level held high gives no further events. With the source select at 0, trigger edges give none.
- R8: With preload at 0, `sw_upd2` and trigger edges leave the active channel set unchanged, whatever the source select holds.
- R9: While run enable is 0, the counter (address 3 and `cnt_o`) holds its value.
- R10: While run enable is 1, the counter counts up by one each cycle. When it has reached the active reload, it wraps to 0 on the next cycle. `upd_o` is high in the cycle before the wrap.
- R11: With `one_pulse_mode` or `slave_trig_mode` high, a rising edge of `trig_in` sets run enable to 1. With both low, it does not.
- R12: When a write to a buffered register and the update event that transfers it fall in the same cycle, the newly written value reaches the active register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 4 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 4 | Read address |
| bus_rdata | output | 32 | Read data, combinational from `bus_raddr` |
| sw_upd | input | 1 | Software update event strobe |
| sw_upd2 | input | 1 | Software second-update event strobe |
| trig_in | input | 1 | Trigger input, synchronous to `clk` |
| one_pulse_mode | input | 1 | Single-pulse mode flag |
| slave_trig_mode | input | 1 | Slave-trigger mode flag |
| tmr_en_o | output | 1 | Current run enable |
| cnt_o | output | CNT_W | Counter value |
| reload_o | output | CNT_W | Active reload value |
| upd_o | output | 1 | Update event (software strobe or wrap) this cycle |
| ch_en_o | output | NCH | Active channel enables |
| ch_nen_o | output | NCH | Active complementary enables |
| ch_mode_o | output | NCH*3 | Active output modes, channel n at bits 3n+2:3n |

## Verification
The hardest state to reach from the ports is a buffered value that differs from the active one while its switch is off. This happens after preload or buffering is turned off with a transfer still pending, and in that state the stray update sources must do nothing. The stimulus fills a buffered channel register under preload, clears preload, and then fires both the software strobe and a fresh trigger edge. Trigger edges need a low phase to re-arm, so the sequence drives the input low and then high again each time. Same-cycle write-plus-event collisions are driven directly in one cycle.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int MODE_W = 3;
    localparam int CH_W   = MODE_W + 2;

    // register addresses
    localparam int A_CTRL    = 0;
    localparam int A_RLD_SHD = 1;
    localparam int A_RLD_ACT = 2;
    localparam int A_CNT     = 3;
    localparam int A_CH_SHD  = 4;

    // control word bit positions
    localparam int B_TME  = 0;
    localparam int B_RBUF = 1;
    localparam int B_PRE  = 8;
    localparam int B_USRC = 9;

    typedef struct packed {
        logic usrc;
        logic pre;
        logic rbuf;
        logic tme;
    } ctl_t;

    // packed so that word bits [4:2]=mode, [1]=nen, [0]=en
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              nen;
        logic              en;
    } ch_ctl_t;

    function automatic ctl_t ctl_from_word(input logic [DATA_W-1:0] w);
        ctl_t c;
        c.tme  = w[B_TME];
        c.rbuf = w[B_RBUF];
        c.pre  = w[B_PRE];
        c.usrc = w[B_USRC];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_to_word(input ctl_t c);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[B_TME]  = c.tme;
        w[B_RBUF] = c.rbuf;
        w[B_PRE]  = c.pre;
        w[B_USRC] = c.usrc;
        return w;
    endfunction

endpackage

// File: rtl/tsu_ctl.sv
module tsu_ctl
    import tsu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  ctl_t wval,
    input  logic trig_in,
    input  logic sw_upd2,
    input  logic hw_mode,
    output ctl_t ctl,
    output logic trig_rise,
    output logic upd2
);
    logic trig_q;
    logic hw_set;

    assign trig_rise = trig_in & ~trig_q;
    assign hw_set    = hw_mode & trig_rise;
    // second update exists only while preload is on
    assign upd2      = ctl.pre & (sw_upd2 | (ctl.usrc & trig_rise));

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            ctl    <= '0;
        end else begin
            trig_q <= trig_in;
            if (wr)
                ctl <= wval;
            if (hw_set)
                ctl.tme <= 1'b1;
        end
    end
endmodule

// File: rtl/tsu_cnt.sv
module tsu_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tme,
    input  logic             rbuf,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             sw_upd,
    output logic [CNT_W-1:0] shd,
    output logic [CNT_W-1:0] act,
    output logic [CNT_W-1:0] cnt,
    output logic             upd
);
    logic             wrap;
    logic [CNT_W-1:0] shd_nx;

    assign wrap   = tme && (cnt >= act);
    assign upd    = sw_upd | wrap;
    assign shd_nx = wr ? wdata : shd;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= '0;
            act <= '0;
            cnt <= '0;
        end else begin
            shd <= shd_nx;
            if (wr && !rbuf)
                act <= wdata;
            else if (upd)
                act <= shd_nx;
            if (wrap)
                cnt <= '0;
            else if (tme)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tsu_chan.sv
module tsu_chan
    import tsu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pre,
    input  logic    wr,
    input  ch_ctl_t wdata,
    input  logic    upd2,
    output ch_ctl_t shd,
    output ch_ctl_t act
);
    ch_ctl_t shd_nx;

    assign shd_nx = wr ? wdata : shd;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= '0;
            act <= '0;
        end else begin
            shd <= shd_nx;
            if (wr && !pre)
                act <= wdata;
            else if (upd2)
                act <= shd_nx;
        end
    end
endmodule

// File: rtl/tmr_shadow_ctl.sv
module tmr_shadow_ctl
    import tsu_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_waddr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [ADDR_W-1:0]     bus_raddr,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  sw_upd,
    input  logic                  sw_upd2,
    input  logic                  trig_in,
    input  logic                  one_pulse_mode,
    input  logic                  slave_trig_mode,
    output logic                  tmr_en_o,
    output logic [CNT_W-1:0]      cnt_o,
    output logic [CNT_W-1:0]      reload_o,
    output logic                  upd_o,
    output logic [NCH-1:0]        ch_en_o,
    output logic [NCH-1:0]        ch_nen_o,
    output logic [NCH*MODE_W-1:0] ch_mode_o
);
    localparam int CH_ACT_BASE = A_CH_SHD + NCH;

    ctl_t             ctl;
    logic             trig_rise;
    logic             upd2;
    logic             wr_ctl;
    logic             wr_rld;
    logic [CNT_W-1:0] rld_shd;
    ch_ctl_t          ch_shd [NCH];
    ch_ctl_t          ch_act [NCH];
    logic [NCH*CH_W-1:0] ch_act_flat;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign wr_ctl = bus_wr && (bus_waddr == ADDR_W'(A_CTRL));
    assign wr_rld = bus_wr && (bus_waddr == ADDR_W'(A_RLD_SHD));

    tsu_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_ctl),
        .wval      (ctl_from_word(bus_wdata)),
        .trig_in   (trig_in),
        .sw_upd2   (sw_upd2),
        .hw_mode   (one_pulse_mode | slave_trig_mode),
        .ctl       (ctl),
        .trig_rise (trig_rise),
        .upd2      (upd2)
    );

    tsu_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tme    (ctl.tme),
        .rbuf   (ctl.rbuf),
        .wr     (wr_rld),
        .wdata  (bus_wdata[CNT_W-1:0]),
        .sw_upd (sw_upd),
        .shd    (rld_shd),
        .act    (reload_o),
        .cnt    (cnt_o),
        .upd    (upd_o)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        logic wr_ch;
        assign wr_ch = bus_wr && (bus_waddr == ADDR_W'(A_CH_SHD + gi));

        tsu_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .pre   (ctl.pre),
            .wr    (wr_ch),
            .wdata (ch_ctl_t'(bus_wdata[CH_W-1:0])),
            .upd2  (upd2),
            .shd   (ch_shd[gi]),
            .act   (ch_act[gi])
        );

        assign ch_en_o[gi]                     = ch_act[gi].en;
        assign ch_nen_o[gi]                    = ch_act[gi].nen;
        assign ch_mode_o[gi*MODE_W +: MODE_W]  = ch_act[gi].mode;
        assign ch_act_flat[gi*CH_W +: CH_W]    = ch_act[gi];
    end

    assign tmr_en_o = ctl.tme;

    always_comb begin
        bus_rdata = '0;
        if (bus_raddr == ADDR_W'(A_CTRL))
            bus_rdata = ctl_to_word(ctl);
        else if (bus_raddr == ADDR_W'(A_RLD_SHD))
            bus_rdata = {{(DATA_W-CNT_W){1'b0}}, rld_shd};
        else if (bus_raddr == ADDR_W'(A_RLD_ACT))
            bus_rdata = {{(DATA_W-CNT_W){1'b0}}, reload_o};
        else if (bus_raddr == ADDR_W'(A_CNT))
            bus_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_o};
        for (int i = 0; i < NCH; i++) begin
            if (bus_raddr == ADDR_W'(A_CH_SHD + i))
                bus_rdata = {{(DATA_W-CH_W){1'b0}}, ch_shd[i]};
            if (bus_raddr == ADDR_W'(CH_ACT_BASE + i))
                bus_rdata = {{(DATA_W-CH_W){1'b0}}, ch_act[i]};
        end
    end
endmodule

// File: rtl/tsu_chk.sv
module tsu_chk
    import tsu_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                tme,
    input logic                rbuf,
    input logic                pre,
    input logic                wr_rld,
    input logic [CNT_W-1:0]    wdata_rld,
    input logic                trig_rise,
    input logic                hw_mode,
    input logic [CNT_W-1:0]    cnt,
    input logic [CNT_W-1:0]    rld_act,
    input logic                upd,
    input logic                upd2,
    input logic [NCH*CH_W-1:0] ch_act_flat,
    input logic [ADDR_W-1:0]   raddr,
    input logic [DATA_W-1:0]   rdata
);
    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (raddr == ADDR_W'(A_CTRL)) |-> ((rdata & ~32'h0000_0303) == '0)); // R1

    AST_RELOAD_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (!rbuf && wr_rld) |=> (rld_act == $past(wdata_rld))); // R3

    AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (rbuf && !upd) |=> $stable(rld_act)); // R4

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
        (pre && !upd2) |=> $stable(ch_act_flat)); // R6

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tme |=> $stable(cnt)); // R9

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tme && (cnt >= rld_act)) |=> (cnt == '0)); // R10

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tme && (cnt < rld_act)) |=> (cnt == $past(cnt) + 1'b1)); // R10

    AST_HW_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (hw_mode && trig_rise) |=> tme); // R11
endmodule

bind tmr_shadow_ctl tsu_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tme         (ctl.tme),
    .rbuf        (ctl.rbuf),
    .pre         (ctl.pre),
    .wr_rld      (wr_rld),
    .wdata_rld   (bus_wdata[CNT_W-1:0]),
    .trig_rise   (trig_rise),
    .hw_mode     (one_pulse_mode | slave_trig_mode),
    .cnt         (cnt_o),
    .rld_act     (reload_o),
    .upd         (upd_o),
    .upd2        (upd2),
    .ch_act_flat (ch_act_flat),
    .raddr       (bus_raddr),
    .rdata       (bus_rdata)
);

// File: tb/tb_tmr_shadow_ctl.sv
module tb_tmr_shadow_ctl;
    localparam int NCH = 4;
    localparam int CNT_W = 16;

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_UPD = 3'd2,
                           OP_UPD2 = 3'd3, OP_TRIG = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 50;
    localparam vec_t VEC [NV] = '{
        '{OP_RD,  4'd0,  32'h0,        32'h0,    4'd2},  // R2
        '{OP_RD,  4'd2,  32'h0,        32'h0,    4'd2},  // R2
        '{OP_RD,  4'd9,  32'h0,        32'h0,    4'd2},  // R2
        '{OP_WR,  4'd1,  32'h1234,     32'h0,    4'd3},  // R3
        '{OP_RD,  4'd2,  32'h0,        32'h1234, 4'd3},  // R3
        '{OP_RD,  4'd1,  32'h0,        32'h1234, 4'd3},  // R3
        '{OP_WR,  4'd4,  32'h1D,       32'h0,    4'd5},  // R5
        '{OP_RD,  4'd8,  32'h0,        32'h1D,   4'd5},  // R5
        '{OP_WR,  4'd0,  32'hFFFFFFFE, 32'h0,    4'd1},  // R1
        '{OP_RD,  4'd0,  32'h0,        32'h302,  4'd1},  // R1
        '{OP_WR,  4'd1,  32'h0BCD,     32'h0,    4'd4},  // R4
        '{OP_RD,  4'd2,  32'h0,        32'h1234, 4'd4},  // R4
        '{OP_RD,  4'd1,  32'h0,        32'h0BCD, 4'd4},  // R4
        '{OP_UPD, 4'd0,  32'h0,        32'h0,    4'd4},  // R4
        '{OP_RD,  4'd2,  32'h0,        32'h0BCD, 4'd4},  // R4
        '{OP_WR,  4'd5,  32'h03,       32'h0,    4'd6},  // R6
        '{OP_RD,  4'd9,  32'h0,        32'h0,    4'd6},  // R6
        '{OP_RD,  4'd5,  32'h0,        32'h03,   4'd6},  // R6
        '{OP_UPD, 4'd0,  32'h0,        32'h0,    4'd6},  // R6
        '{OP_RD,  4'd9,  32'h0,        32'h0,    4'd6},  // R6
        '{OP_UPD2,4'd0,  32'h0,        32'h0,    4'd6},  // R6
        '{OP_RD,  4'd9,  32'h0,        32'h03,   4'd6},  // R6
        '{OP_WR,  4'd6,  32'h0A,       32'h0,    4'd7},  // R7
        '{OP_TRIG,4'd0,  32'h1,        32'h0,    4'd7},  // R7
        '{OP_RD,  4'd10, 32'h0,        32'h0A,   4'd7},  // R7
        '{OP_WR,  4'd6,  32'h07,       32'h0,    4'd7},  // R7
        '{OP_TRIG,4'd0,  32'h1,        32'h0,    4'd7},  // R7
        '{OP_RD,  4'd10, 32'h0,        32'h0A,   4'd7},  // R7
        '{OP_TRIG,4'd0,  32'h0,        32'h0,    4'd7},  // R7
        '{OP_TRIG,4'd0,  32'h1,        32'h0,    4'd7},  // R7
        '{OP_RD,  4'd10, 32'h0,        32'h07,   4'd7},  // R7
        '{OP_WR,  4'd0,  32'h102,      32'h0,    4'd7},  // R7
        '{OP_WR,  4'd7,  32'h1F,       32'h0,    4'd7},  // R7
        '{OP_TRIG,4'd0,  32'h0,        32'h0,    4'd7},  // R7
        '{OP_TRIG,4'd0,  32'h1,        32'h0,    4'd7},  // R7
        '{OP_RD,  4'd11, 32'h0,        32'h0,    4'd7},  // R7
        '{OP_UPD2,4'd0,  32'h0,        32'h0,    4'd6},  // R6
        '{OP_RD,  4'd11, 32'h0,        32'h1F,   4'd6},  // R6
        '{OP_WR,  4'd7,  32'h02,       32'h0,    4'd8},  // R8
        '{OP_WR,  4'd0,  32'h002,      32'h0,    4'd8},  // R8
        '{OP_UPD2,4'd0,  32'h0,        32'h0,    4'd8},  // R8
        '{OP_RD,  4'd11, 32'h0,        32'h1F,   4'd8},  // R8
        '{OP_WR,  4'd0,  32'h202,      32'h0,    4'd8},  // R8
        '{OP_TRIG,4'd0,  32'h0,        32'h0,    4'd8},  // R8
        '{OP_TRIG,4'd0,  32'h1,        32'h0,    4'd8},  // R8
        '{OP_RD,  4'd11, 32'h0,        32'h1F,   4'd8},  // R8
        '{OP_RD,  4'd0,  32'h0,        32'h202,  4'd11}, // R11
        '{OP_WR,  4'd7,  32'h04,       32'h0,    4'd5},  // R5
        '{OP_RD,  4'd11, 32'h0,        32'h04,   4'd5},  // R5
        '{OP_RD,  4'd3,  32'h0,        32'h0,    4'd9}   // R9
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  bus_wr = 1'b0;
    logic [3:0]            bus_waddr = '0;
    logic [31:0]           bus_wdata = '0;
    logic [3:0]            bus_raddr = '0;
    logic [31:0]           bus_rdata;
    logic                  sw_upd = 1'b0;
    logic                  sw_upd2 = 1'b0;
    logic                  trig_in = 1'b0;
    logic                  one_pulse_mode = 1'b0;
    logic                  slave_trig_mode = 1'b0;
    logic                  tmr_en_o;
    logic [CNT_W-1:0]      cnt_o;
    logic [CNT_W-1:0]      reload_o;
    logic                  upd_o;
    logic [NCH-1:0]        ch_en_o;
    logic [NCH-1:0]        ch_nen_o;
    logic [NCH*3-1:0]      ch_mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmr_shadow_ctl #(.NCH(NCH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .sw_upd(sw_upd), .sw_upd2(sw_upd2), .trig_in(trig_in),
        .one_pulse_mode(one_pulse_mode), .slave_trig_mode(slave_trig_mode),
        .tmr_en_o(tmr_en_o), .cnt_o(cnt_o), .reload_o(reload_o), .upd_o(upd_o),
        .ch_en_o(ch_en_o), .ch_nen_o(ch_nen_o), .ch_mode_o(ch_mode_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        bus_wr  = 1'b0;
        sw_upd  = 1'b0;
        sw_upd2 = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        tick();
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_raddr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [CNT_W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:   wr(VEC[i].addr, VEC[i].data);
                OP_UPD:  begin sw_upd = 1'b1; tick(); end
                OP_UPD2: begin sw_upd2 = 1'b1; tick(); end
                OP_TRIG: begin trig_in = VEC[i].data[0]; tick(); end
                default: rd_chk($sformatf("R%0d vec %0d", VEC[i].req, i),
                                VEC[i].addr, VEC[i].exp);
            endcase
        end

        // R12: reload write and update event in the same cycle (buffered)
        wr(4'd0, 32'h002);
        bus_wr = 1'b1; bus_waddr = 4'd1; bus_wdata = 32'h55; sw_upd = 1'b1;
        tick();
        chk("R12 reload", {16'h0, reload_o}, 32'h55);

        // R12: channel write and second update in the same cycle (preload)
        wr(4'd0, 32'h100);
        bus_wr = 1'b1; bus_waddr = 4'd6; bus_wdata = 32'h15; sw_upd2 = 1'b1;
        tick();
        rd_chk("R12 chan", 4'd10, 32'h15);
        chk("R12 chan mode", {29'h0, ch_mode_o[8:6]}, 32'h5);
        chk("R12 chan en", {31'h0, ch_en_o[2]}, 32'h1);

        // R10: run with reload 3, observe count and wrap
        wr(4'd1, 32'h3);
        wr(4'd0, 32'h001);
        chk("R10 start", {16'h0, cnt_o}, 32'h0);
        tick(); chk("R10 cnt1", {16'h0, cnt_o}, 32'h1);
        tick(); chk("R10 cnt2", {16'h0, cnt_o}, 32'h2);
        tick(); chk("R10 cnt3", {16'h0, cnt_o}, 32'h3);
        chk("R10 upd", {31'h0, upd_o}, 32'h1);
        tick(); chk("R10 wrap", {16'h0, cnt_o}, 32'h0);

        // R4: buffered reload transferred by counter wrap
        wr(4'd0, 32'h003);
        wr(4'd1, 32'h1);
        if (upd_o) begin
            tick();
            chk("R4 held", {16'h0, reload_o}, 32'h3);
            wr(4'd1, 32'h1);
        end
        chk("R4 held", {16'h0, reload_o}, 32'h3);
        for (int k = 0; k < 10; k++) begin
            if (upd_o) break;
            tick();
        end
        tick();
        chk("R4 wrap load", {16'h0, reload_o}, 32'h1);
        chk("R4 wrap cnt", {16'h0, cnt_o}, 32'h0);

        // R9: stopped counter holds
        wr(4'd0, 32'h000);
        held = cnt_o;
        repeat (5) tick();
        chk("R9 hold", {16'h0, cnt_o}, {16'h0, held});

        // R11: hardware enable in single-pulse and slave-trigger modes
        trig_in = 1'b0; tick();
        one_pulse_mode = 1'b1;
        trig_in = 1'b1; tick();
        chk("R11 single pulse", {31'h0, tmr_en_o}, 32'h1);
        one_pulse_mode = 1'b0;
        wr(4'd0, 32'h000);
        trig_in = 1'b0; tick();
        slave_trig_mode = 1'b1;
        trig_in = 1'b1; tick();
        chk("R11 slave trig", {31'h0, tmr_en_o}, 32'h1);
        slave_trig_mode = 1'b0;

        // R2: reset in the middle of operation
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R2 cnt", {16'h0, cnt_o}, 32'h0);
        chk("R2 reload", {16'h0, reload_o}, 32'h0);
        chk("R2 chan", {23'h0, ch_en_o, ch_nen_o[0], ch_mode_o[3:0]}, 32'h0);
        rd_chk("R2 ctrl", 4'd0, 32'h0);

        finish_run();
    end
endmodule